// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Datapath

This block is a single-cycle arithmetic unit for signal-processing code. It holds two independent 40-bit accumulators. Each cycle it takes one command: an opcode, an accumulator select, mode bits and two 16-bit signed operands. The multiplier sign-extends both operands to 17 bits and multiplies them. In integer mode the product is used as is. In fractional mode the product is doubled, so that two 1.15 values give a 1.31 result in bits 31:0, with 8 guard bits above it.

The product can be loaded into the selected accumulator, added to it or subtracted from it. The unit can also shift the selected accumulator arithmetically by up to 16 places in either direction, or clear it. Every update passes through an optional saturation stage. That stage clamps either to the full 40-bit signed range or to the 32-bit 1.31 range.

Each update also produces a 16-bit write-back value: bits 31:16 of the new accumulator, convergently rounded and saturated to 16 bits. A store command produces the same write-back value from the selected accumulator without changing it. Two flags are reported for each accumulator:
- a guard flag, set while the value has spilled into the guard bits;
- a sticky flag, set when an unsaturated result left the 40-bit range.

Top module: `macUnit`

## Requirements
- R1: While `rstN` is low, and after its release until the first command, both accumulators, `wbData`, `ovfFull` and `ovfGuard` are zero.
- R2: Opcode values are 0 idle, 1 load, 2 add, 3 subtract, 4 shift, 5 clear, 6 store and 7 reserved. With `fracMode`=0, a load puts the signed product of the two operands, sign-extended to 40 bits, into the accumulator chosen by `accSel` (0 gives `accOut0`, 1 gives `accOut1`). The new value is visible after the next rising edge.
- R3: With `fracMode`=1, the product is doubled before it is used, so that 0x8000 times 0x8000 loads +2^31.
- R4: Add and subtract change only the selected accumulator, by plus or minus the product. The other accumulator is unchanged by every command.
- R5: With `satEn`=0, the result of any load, add, subtract or shift wraps modulo 2^40.
- R6: With `satEn`=1 and `satSuper`=0, a result outside the 40-bit signed range is clamped to -2^39 or 2^39-1.
- R7: With `satEn`=1 and `satSuper`=1, a result is clamped to the range -2^31 to 2^31-1.
- R8: A shift command moves the selected accumulator left by `shiftAmt` when that value is positive. When it is negative, it moves the accumulator arithmetically right by its magnitude. Amounts beyond ±16 act as ±16.
- R9: After a load, add, subtract, shift or clear, `wbData` holds bits 31:16 of the new value, rounded to nearest with ties to even on bits 15:0 and saturated to the 16-bit signed range. A store sets `wbData` the same way from the selected accumulator and leaves both accumulators unchanged. The idle and reserved codes change nothing.
- R10: `ovfFull[i]` is set when an update of accumulator i gave a pre-saturation result outside the 40-bit range. It stays set until a clear of that accumulator.
- R11: `ovfGuard[i]` is 1 exactly when bits 39:31 of accumulator i are not all equal.
- R12: A clear command sets the selected accumulator to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| op | input | 3 | Command code |
| accSel | input | 1 | Target accumulator |
| fracMode | input | 1 | 1 = fractional product, 0 = integer |
| satEn | input | 1 | Enable saturation on update |
| satSuper | input | 1 | 1 = clamp to the 32-bit range, 0 = clamp to the 40-bit range |
| opA | input | 16 | Signed operand A |
| opB | input | 16 | Signed operand B |
| shiftAmt | input | 6 | Signed shift amount, positive = left |
| accOut0 | output | 40 | Accumulator 0 |
| accOut1 | output | 40 | Accumulator 1 |
| wbData | output | 16 | Rounded write-back result |
| ovfGuard | output | 2 | Per-accumulator guard-bit overflow |
| ovfFull | output | 2 | Per-accumulator sticky 40-bit overflow |

## Verification
The properties take for granted that every input is known at each rising edge and that the mode bits belong to the command sampled on the same edge. Under that assumption, a saturated update, a stable unselected accumulator or a rising sticky flag can each be traced back to the single command before it. The stimulus changes inputs only at the falling edge and never leaves them unknown. Its random draws include the reserved code and shift amounts beyond ±16, so that the clamping and no-effect behaviour is exercised inside those assumptions.

// File: rtl/macPkg.sv
package macPkg;
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_ADD   = 3'd2,
    OP_SUB   = 3'd3,
    OP_SHIFT = 3'd4,
    OP_CLR   = 3'd5,
    OP_STORE = 3'd6,
    OP_RSVD  = 3'd7
  } opT;

  typedef enum logic [2:0] {
    SRC_PROD, SRC_ADD, SRC_SUB, SRC_SHIFT, SRC_ZERO, SRC_HOLD
  } srcT;

  typedef struct packed {
    logic writeAcc;
    logic wbEn;
    logic clrFlag;
    srcT  src;
  } ctrlT;
endpackage

// File: rtl/macCtrl.sv
module macCtrl
  import macPkg::*;
(
  input  logic [2:0] op,
  output ctrlT       ctl
);
  always_comb begin
    ctl = '{writeAcc: 1'b0, wbEn: 1'b0, clrFlag: 1'b0, src: SRC_HOLD};
    unique case (opT'(op))
      OP_LOAD:  ctl = '{writeAcc: 1'b1, wbEn: 1'b1, clrFlag: 1'b0, src: SRC_PROD};
      OP_ADD:   ctl = '{writeAcc: 1'b1, wbEn: 1'b1, clrFlag: 1'b0, src: SRC_ADD};
      OP_SUB:   ctl = '{writeAcc: 1'b1, wbEn: 1'b1, clrFlag: 1'b0, src: SRC_SUB};
      OP_SHIFT: ctl = '{writeAcc: 1'b1, wbEn: 1'b1, clrFlag: 1'b0, src: SRC_SHIFT};
      OP_CLR:   ctl = '{writeAcc: 1'b1, wbEn: 1'b1, clrFlag: 1'b1, src: SRC_ZERO};
      OP_STORE: ctl = '{writeAcc: 1'b0, wbEn: 1'b1, clrFlag: 1'b0, src: SRC_HOLD};
      default:  ctl = '{writeAcc: 1'b0, wbEn: 1'b0, clrFlag: 1'b0, src: SRC_HOLD};
    endcase
  end
endmodule

// File: rtl/macDatapath.sv
module macDatapath
  import macPkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ACC_W     = 40,
  parameter int SHIFT_MAX = 16,
  parameter int SH_W      = $clog2(SHIFT_MAX) + 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlT                     ctl,
  input  logic                     accSel,
  input  logic                     fracMode,
  input  logic                     satEn,
  input  logic                     satSuper,
  input  logic [DATA_W-1:0]        opA,
  input  logic [DATA_W-1:0]        opB,
  input  logic signed [SH_W-1:0]   shiftAmt,
  output logic [ACC_W-1:0]         accOut0,
  output logic [ACC_W-1:0]         accOut1,
  output logic [DATA_W-1:0]        wbData,
  output logic [1:0]               ovfGuard,
  output logic [1:0]               ovfFull
);
  localparam int NUM_ACC   = 2;
  localparam int PROD_W    = 2 * (DATA_W + 1);
  localparam int WIDE_W    = ACC_W + SHIFT_MAX + 2;
  localparam int FRAC_BITS = 2 * DATA_W - 1;
  localparam int RND_W     = ACC_W - DATA_W + 1;
  localparam logic signed [WIDE_W-1:0] ONE     = 1;
  localparam logic signed [WIDE_W-1:0] MAX_ACC = (ONE <<< (ACC_W - 1)) - ONE;
  localparam logic signed [WIDE_W-1:0] MIN_ACC = -(ONE <<< (ACC_W - 1));
  localparam logic signed [WIDE_W-1:0] MAX_FR  = (ONE <<< FRAC_BITS) - ONE;
  localparam logic signed [WIDE_W-1:0] MIN_FR  = -(ONE <<< FRAC_BITS);
  localparam logic signed [RND_W-1:0]  RONE    = 1;
  localparam logic signed [RND_W-1:0]  MAX_WB  = (RONE <<< (DATA_W - 1)) - RONE;
  localparam logic signed [RND_W-1:0]  MIN_WB  = -(RONE <<< (DATA_W - 1));
  localparam logic [DATA_W-1:0]        HALF    = 1 << (DATA_W - 1);

  logic signed [ACC_W-1:0] accQ [NUM_ACC];
  logic [NUM_ACC-1:0]      fullQ;
  logic [DATA_W-1:0]       wbQ;

  // multiplier: 17x17 signed, optional fractional doubling
  logic signed [DATA_W:0]   aExt, bExt;
  logic signed [PROD_W-1:0] prod;
  logic signed [WIDE_W-1:0] prodSx, prodW;
  assign aExt   = {opA[DATA_W-1], opA};
  assign bExt   = {opB[DATA_W-1], opB};
  assign prod   = aExt * bExt;
  assign prodSx = WIDE_W'(prod);
  assign prodW  = fracMode ? (prodSx <<< 1) : prodSx;

  // barrel shifter on the selected accumulator
  logic signed [ACC_W-1:0]  curAcc;
  logic signed [WIDE_W-1:0] curW, shifted;
  logic [SH_W-1:0]          shMagRaw, shMag;
  logic                     shLeft;
  assign curAcc   = accQ[accSel];
  assign curW     = WIDE_W'(curAcc);
  assign shLeft   = !shiftAmt[SH_W-1];
  assign shMagRaw = shLeft ? shiftAmt : -shiftAmt;
  assign shMag    = (shMagRaw > SH_W'(SHIFT_MAX)) ? SH_W'(SHIFT_MAX) : shMagRaw;
  assign shifted  = shLeft ? (curW <<< shMag) : (curW >>> shMag);

  // update value, overflow detection, saturation
  logic signed [WIDE_W-1:0] wide, hiLim, loLim, clamped;
  logic signed [ACC_W-1:0]  newAcc;
  logic                     ovfWide;
  always_comb begin
    unique case (ctl.src)
      SRC_PROD:  wide = prodW;
      SRC_ADD:   wide = curW + prodW;
      SRC_SUB:   wide = curW - prodW;
      SRC_SHIFT: wide = shifted;
      SRC_ZERO:  wide = '0;
      default:   wide = curW;
    endcase
  end
  assign ovfWide = (wide > MAX_ACC) || (wide < MIN_ACC);
  assign hiLim   = satSuper ? MAX_FR : MAX_ACC;
  assign loLim   = satSuper ? MIN_FR : MIN_ACC;
  assign clamped = (wide > hiLim) ? hiLim : ((wide < loLim) ? loLim : wide);
  assign newAcc  = satEn ? clamped[ACC_W-1:0] : wide[ACC_W-1:0];

  // convergent rounding of bits 31:16 with 16-bit saturation
  logic signed [ACC_W-1:0] rndSrc;
  logic signed [RND_W-1:0] hiPart, rounded;
  logic [DATA_W-1:0]       loPart;
  logic                    rndUp;
  assign rndSrc  = ctl.writeAcc ? newAcc : curAcc;
  assign hiPart  = RND_W'(rndSrc >>> DATA_W);
  assign loPart  = rndSrc[DATA_W-1:0];
  assign rndUp   = (loPart > HALF) || ((loPart == HALF) && hiPart[0]);
  assign rounded = hiPart + signed'({{(RND_W-1){1'b0}}, rndUp});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbQ <= '0;
    end else if (ctl.wbEn) begin
      if (rounded > MAX_WB)      wbQ <= MAX_WB[DATA_W-1:0];
      else if (rounded < MIN_WB) wbQ <= MIN_WB[DATA_W-1:0];
      else                       wbQ <= rounded[DATA_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_ACC; g++) begin : gAcc
    always_ff @(posedge clk) begin
      if (!rstN) begin
        accQ[g]  <= '0;
        fullQ[g] <= 1'b0;
      end else if (ctl.writeAcc && (accSel == 1'(g))) begin
        accQ[g]  <= newAcc;
        fullQ[g] <= ctl.clrFlag ? 1'b0 : (fullQ[g] | ovfWide);
      end
    end
    assign ovfGuard[g] = !((&accQ[g][ACC_W-1:FRAC_BITS]) || !(|accQ[g][ACC_W-1:FRAC_BITS]));
  end

  assign accOut0 = accQ[0];
  assign accOut1 = accQ[1];
  assign ovfFull = fullQ;
  assign wbData  = wbQ;
endmodule

// File: rtl/macUnit.sv
module macUnit
  import macPkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ACC_W     = 40,
  parameter int SHIFT_MAX = 16,
  parameter int SH_W      = $clog2(SHIFT_MAX) + 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [2:0]             op,
  input  logic                   accSel,
  input  logic                   fracMode,
  input  logic                   satEn,
  input  logic                   satSuper,
  input  logic [DATA_W-1:0]      opA,
  input  logic [DATA_W-1:0]      opB,
  input  logic signed [SH_W-1:0] shiftAmt,
  output logic [ACC_W-1:0]       accOut0,
  output logic [ACC_W-1:0]       accOut1,
  output logic [DATA_W-1:0]      wbData,
  output logic [1:0]             ovfGuard,
  output logic [1:0]             ovfFull
);
  ctrlT ctl;

  macCtrl ctrl_i (.op(op), .ctl(ctl));

  macDatapath #(
    .DATA_W(DATA_W), .ACC_W(ACC_W), .SHIFT_MAX(SHIFT_MAX), .SH_W(SH_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .accSel(accSel),
    .fracMode(fracMode), .satEn(satEn), .satSuper(satSuper),
    .opA(opA), .opB(opB), .shiftAmt(shiftAmt),
    .accOut0(accOut0), .accOut1(accOut1), .wbData(wbData),
    .ovfGuard(ovfGuard), .ovfFull(ovfFull)
  );
endmodule

// File: rtl/macUnitChk.sv
module macUnitChk #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        op,
  input logic              accSel,
  input logic              satEn,
  input logic              satSuper,
  input logic [ACC_W-1:0]  accOut0,
  input logic [ACC_W-1:0]  accOut1,
  input logic [DATA_W-1:0] wbData,
  input logic [1:0]        ovfFull
);
  localparam int FB = 2 * DATA_W - 1;

  // R7
  sat_super0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (satEn && satSuper && !accSel && op inside {3'd1, 3'd2, 3'd3, 3'd4})
    |=> ((&accOut0[ACC_W-1:FB]) || !(|accOut0[ACC_W-1:FB])));

  // R4
  other_acc1_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!accSel) |=> $stable(accOut1));

  // R4
  other_acc0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accSel) |=> $stable(accOut0));

  // R12
  clear_acc0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (op == 3'd5 && !accSel) |=> (accOut0 == '0));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (op == 3'd0 || op == 3'd7) |=> ($stable(accOut0) && $stable(accOut1) && $stable(wbData)));

  // R10
  sticky_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFull[0]) |-> $past(op inside {3'd1, 3'd2, 3'd3, 3'd4} && !accSel));
endmodule

bind macUnit macUnitChk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) chk_i (
  .clk(clk), .rstN(rstN), .op(op), .accSel(accSel), .satEn(satEn),
  .satSuper(satSuper), .accOut0(accOut0), .accOut1(accOut1),
  .wbData(wbData), .ovfFull(ovfFull)
);

// File: tb/macUnit_tb_top.sv
module macUnit_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] op = '0;
  logic accSel = 1'b0, fracMode = 1'b0, satEn = 1'b0, satSuper = 1'b0;
  logic [15:0] opA = '0, opB = '0;
  logic signed [5:0] shiftAmt = '0;
  logic [39:0] accOut0, accOut1;
  logic [15:0] wbData;
  logic [1:0] ovfGuard, ovfFull;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  longint mAcc [2];
  bit     mFull [2];
  longint mWb;

  localparam longint MAX40 = (64'sd1 <<< 39) - 1;
  localparam longint MIN40 = -(64'sd1 <<< 39);
  localparam longint MAX32 = (64'sd1 <<< 31) - 1;
  localparam longint MIN32 = -(64'sd1 <<< 31);

  always #2.5 clk = ~clk;

  macUnit dut_i (
    .clk(clk), .rstN(rstN), .op(op), .accSel(accSel), .fracMode(fracMode),
    .satEn(satEn), .satSuper(satSuper), .opA(opA), .opB(opB),
    .shiftAmt(shiftAmt), .accOut0(accOut0), .accOut1(accOut1),
    .wbData(wbData), .ovfGuard(ovfGuard), .ovfFull(ovfFull)
  );

  function automatic longint sx40(longint v);
    return (v <<< 24) >>> 24;
  endfunction

  function automatic longint roundWb(longint v);
    longint hi = v >>> 16;
    longint lo = v & 64'hFFFF;
    if (lo > 64'h8000 || (lo == 64'h8000 && (hi & 1) == 1)) hi = hi + 1;
    if (hi > 32767) hi = 32767;
    if (hi < -32768) hi = -32768;
    return hi;
  endfunction

  function automatic bit guardOf(longint v);
    return (v > MAX32) || (v < MIN32);
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compareAll(string tag, int sel);
    check(tag, sx40(longint'(sel ? accOut1 : accOut0)), mAcc[sel]);
    check("R4 other", sx40(longint'(sel ? accOut0 : accOut1)), mAcc[1-sel]);
    check("R9 wb", longint'($signed(wbData)), mWb);
    check("R10 full0", longint'(ovfFull[0]), longint'(mFull[0]));
    check("R10 full1", longint'(ovfFull[1]), longint'(mFull[1]));
    check("R11 guard0", longint'(ovfGuard[0]), longint'(guardOf(mAcc[0])));
    check("R11 guard1", longint'(ovfGuard[1]), longint'(guardOf(mAcc[1])));
  endtask

  task automatic doOp(int o, int sel, bit fr, bit se, bit ss, int a, int b, int sh);
    longint cur, prod, wide, nv;
    bit wr, ovf;
    int amt;
    string tag;
    op = 3'(o); accSel = sel[0]; fracMode = fr; satEn = se; satSuper = ss;
    opA = 16'(a); opB = 16'(b); shiftAmt = 6'(sh);
    cur  = mAcc[sel];
    prod = longint'($signed(16'(a))) * longint'($signed(16'(b)));
    if (fr) prod = prod * 2;
    amt = sh;
    if (amt > 16) amt = 16;
    if (amt < -16) amt = -16;
    case (o)
      1: wide = prod;
      2: wide = cur + prod;
      3: wide = cur - prod;
      4: wide = (amt >= 0) ? (cur <<< amt) : (cur >>> (-amt));
      5: wide = 0;
      default: wide = cur;
    endcase
    wr  = (o >= 1 && o <= 5);
    ovf = (wide > MAX40) || (wide < MIN40);
    if (se) begin
      nv = wide;
      if (ss) begin
        if (nv > MAX32) nv = MAX32;
        if (nv < MIN32) nv = MIN32;
      end else begin
        if (nv > MAX40) nv = MAX40;
        if (nv < MIN40) nv = MIN40;
      end
    end else nv = sx40(wide);
    case (o)
      1: tag = fr ? "R3 frac load" : "R2 int load";
      2, 3: tag = "R4 add/sub";
      4: tag = "R8 shift";
      5: tag = "R12 clear";
      default: tag = "R9 store/idle";
    endcase
    if (wr && se && ss && nv != wide) tag = "R7 sat32";
    else if (wr && se && nv != wide) tag = "R6 sat40";
    else if (wr && !se && ovf) tag = "R5 wrap";
    if (wr) begin
      mAcc[sel] = nv;
      mFull[sel] = (o == 5) ? 1'b0 : (mFull[sel] | ovf);
      mWb = roundWb(nv);
    end else if (o == 6) mWb = roundWb(cur);
    @(posedge clk);
    @(negedge clk);
    compareAll(tag, sel);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    mAcc[0] = 0; mAcc[1] = 0; mFull[0] = 0; mFull[1] = 0; mWb = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 acc0", longint'(accOut0), 0);
    check("R1 acc1", longint'(accOut1), 0);
    check("R1 wb", longint'(wbData), 0);
    check("R1 flags", longint'({ovfFull, ovfGuard}), 0);
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1 after release", 0);

    // R2 integer products, R3 fractional
    doOp(1, 0, 0, 0, 0, 16'h7FFF, 16'h7FFF, 0);
    doOp(1, 1, 0, 0, 0, 16'h8000, 16'h0003, 0);
    doOp(1, 0, 1, 0, 0, 16'h8000, 16'h8000, 0);   // R3 +2^31, guard set
    doOp(1, 1, 1, 0, 0, 16'h4000, 16'hC000, 0);
    // R4 add/sub on either accumulator
    doOp(2, 1, 1, 0, 0, 16'h2000, 16'h2000, 0);
    doOp(3, 0, 0, 0, 0, 16'h1234, 16'h0F0F, 0);
    // R8 shifts, including clamped amounts
    doOp(1, 0, 0, 0, 0, 16'h1234, 16'h0567, 0);
    doOp(4, 0, 0, 0, 0, 0, 0, 5);
    doOp(4, 0, 0, 0, 0, 0, 0, -9);
    doOp(4, 0, 0, 0, 0, 0, 0, 25);
    doOp(4, 0, 0, 0, 0, 0, 0, -30);
    // R5 wrap, R10 sticky, R6 sat40, R7 sat32
    doOp(1, 0, 1, 0, 0, 16'h8000, 16'h8000, 0);
    doOp(4, 0, 0, 0, 0, 0, 0, 8);                  // R5 2^39 wraps
    doOp(1, 1, 1, 0, 0, 16'h8000, 16'h8000, 0);
    doOp(4, 1, 0, 1, 0, 0, 0, 16);                 // R6 clamp high
    doOp(3, 1, 1, 1, 1, 16'h7FFF, 16'h7FFF, 0);    // R7 clamp to 32-bit
    doOp(5, 0, 0, 0, 0, 0, 0, 0);                  // R12 clear, R10 flag cleared
    // R9 convergent rounding ties
    doOp(1, 0, 0, 0, 0, 2, 16'h4000, 0);           // 0x8000 -> 0
    doOp(1, 0, 0, 0, 0, 6, 16'h4000, 0);           // 0x18000 -> 2
    doOp(1, 1, 1, 0, 0, 16'h7FFF, 16'h7FFF, 0);
    doOp(6, 0, 0, 0, 0, 0, 0, 0);                  // R9 store acc0
    doOp(0, 1, 0, 0, 0, 16'h1111, 16'h2222, 3);    // R9 idle
    doOp(7, 0, 0, 0, 0, 16'h1111, 16'h2222, 3);    // R9 reserved

    for (int i = 0; i < 4000; i++) begin
      int o, a, b;
      o = int'($urandom_range(7, 0));
      case ($urandom_range(3, 0))
        0: a = 16'h8000;
        1: a = 16'h7FFF;
        default: a = int'($urandom_range(16'hFFFF, 0));
      endcase
      b = ($urandom_range(3, 0) == 0) ? 16'h8000 : int'($urandom_range(16'hFFFF, 0));
      doOp(o, int'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
           1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), a, b,
           int'($urandom_range(40, 0)) - 20);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule